// File: doc/BRIEF.md
# Two-Level Hypercube Next-Hop Router

This block makes the next-hop decision for one node of a two-level network in which small clusters of nodes are joined by a binary hypercube, and one gateway node per cluster is joined to the gateways of other clusters by a second binary hypercube. Each cycle it may be given the node's own address, a destination address and a request strobe. One cycle later it reports one of three choices. The message may be delivered to this node. It may leave on one of the in-cluster dimension links. Or it may leave on the upper-level port toward a neighbouring cluster.

The low `LOC_W` bits of an address name a node inside its cluster, and the remaining high bits name the cluster. The gateway of every cluster is the node whose local part is zero. Traffic between clusters first goes to the gateway of its own cluster. It then crosses the upper level one cluster bit at a time, lowest differing bit first. Finally it descends inside the destination cluster. When more than one in-cluster link lies on a shortest path, the router keeps a saturating message count per link and sends the message on the least used link. A mode input can replace this with a pseudo-random choice among the eligible links.

Top module: `hhr_router`

## Requirements
- R1: `port_valid_o` is high in the cycle after a clock edge that samples `req_valid_i` high, and low after any edge that samples it low. After a synchronous reset it is low.
- R2: When the destination equals the node's own address, the decision is local delivery: `port_kind_o` = 0 and `port_dim_o` = 0.
- R3: When both addresses share the same cluster bits (address bits ADDR_W-1..LOC_W) but differ, `port_kind_o` = 1 (in-cluster link). `port_dim_o` is a local bit position (0..LOC_W-1) at which the two addresses differ.
- R4: When the cluster bits differ and the node's local part is nonzero, `port_kind_o` = 1. `port_dim_o` is a bit position at which the node's own local part is 1, so the message moves toward local address 0.
- R5: When the cluster bits differ and the node's local part is zero, `port_kind_o` = 2 (upper-level port). `port_dim_o` is the index, counted from address bit LOC_W as 0, of the lowest cluster bit that differs.
- R6: With `mode_rand_i` = 0, the chosen link is the eligible link with the smallest message count. Ties go to the lowest index.
- R7: Each in-cluster decision adds one to the count of the chosen link in either mode, at the same edge that issues the decision. Local and upper-level decisions leave all counts unchanged.
- R8: A link count stops at 2^CNT_W-1 and does not wrap.
- R9: With `mode_rand_i` = 1, the link is drawn from the eligible set using a 16-bit LFSR that advances once per request. The chosen link is always eligible.
- R10: Reset clears every link count to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_rand_i | input | 1 | 0 = least-count choice, 1 = random choice |
| req_valid_i | input | 1 | Request strobe |
| self_addr_i | input | ADDR_W | Address of this node |
| dest_addr_i | input | ADDR_W | Destination address of the message |
| port_valid_o | output | 1 | Registered decision valid |
| port_kind_o | output | 2 | 0 local, 1 in-cluster link, 2 upper-level port |
| port_dim_o | output | DIM_W | Link dimension or upper-level cluster bit index |

## Verification
The bound checker watches four things on every cycle: the one-cycle alignment of the valid output, local delivery for self-addressed messages, eligibility of the chosen in-cluster dimension, and use of the upper-level port only from a gateway node. The bench's scenarios are needed for the behaviour that depends on history. That covers least-count selection with its lowest-index tie rule, increments that happen only on in-cluster decisions, saturation of a count after hundreds of messages on one link, and the clearing of counts by reset. These can only be seen through later choices.

// File: rtl/hhr_pkg.sv
package hhr_pkg;
  localparam logic [1:0] KIND_LOCAL   = 2'd0;
  localparam logic [1:0] KIND_CLUSTER = 2'd1;
  localparam logic [1:0] KIND_UPPER   = 2'd2;
endpackage

// File: rtl/hhr_lfsr.sv
module hhr_lfsr #(
  parameter logic [15:0] SEED = 16'hACE1
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        step_i,
  output logic [15:0] value_o
);
  logic [15:0] state_q;
  logic        fb;

  assign fb = state_q[15] ^ state_q[13] ^ state_q[12] ^ state_q[10];

  always_ff @(posedge clk) begin
    if (rst) state_q <= SEED;
    else if (step_i) state_q <= {state_q[14:0], fb};
  end

  assign value_o = state_q;
endmodule

// File: rtl/hhr_link_counters.sv
module hhr_link_counters #(
  parameter int LOC_W = 3,
  parameter int CNT_W = 8,
  parameter int DIM_W = 3
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        inc_i,
  input  logic [DIM_W-1:0]            idx_i,
  output logic [LOC_W-1:0][CNT_W-1:0] count_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  for (genvar g = 0; g < LOC_W; g++) begin : g_cnt
    logic [CNT_W-1:0] cnt_q;
    always_ff @(posedge clk) begin
      if (rst) cnt_q <= '0;
      else if (inc_i && (idx_i == DIM_W'(g)) && (cnt_q != CNT_MAX))
        cnt_q <= cnt_q + 1'b1;
    end
    assign count_o[g] = cnt_q;
  end
endmodule

// File: rtl/hhr_pick_least.sv
module hhr_pick_least #(
  parameter int LOC_W = 3,
  parameter int CNT_W = 8,
  parameter int DIM_W = 3
) (
  input  logic [LOC_W-1:0]            mask_i,
  input  logic [LOC_W-1:0][CNT_W-1:0] count_i,
  output logic [DIM_W-1:0]            idx_o
);
  logic [CNT_W-1:0] best_cnt;
  logic             found;

  always_comb begin
    idx_o    = '0;
    best_cnt = '1;
    found    = 1'b0;
    for (int i = 0; i < LOC_W; i++) begin
      if (mask_i[i] && (!found || (count_i[i] < best_cnt))) begin
        found    = 1'b1;
        best_cnt = count_i[i];
        idx_o    = DIM_W'(i);
      end
    end
  end
endmodule

// File: rtl/hhr_pick_random.sv
module hhr_pick_random #(
  parameter int LOC_W = 3,
  parameter int DIM_W = 3
) (
  input  logic [LOC_W-1:0] mask_i,
  input  logic [15:0]      rnd_i,
  output logic [DIM_W-1:0] idx_o
);
  int k;
  int r;
  int seen;

  always_comb begin
    k = 0;
    for (int i = 0; i < LOC_W; i++) k = k + int'(mask_i[i]);
    r     = (k > 0) ? (int'(rnd_i) % k) : 0;
    seen  = 0;
    idx_o = '0;
    for (int i = 0; i < LOC_W; i++) begin
      if (mask_i[i]) begin
        if (seen == r) idx_o = DIM_W'(i);
        seen = seen + 1;
      end
    end
  end
endmodule

// File: rtl/hhr_router.sv
module hhr_router #(
  parameter int          ADDR_W = 6,
  parameter int          LOC_W  = 3,
  parameter int          CNT_W  = 8,
  parameter logic [15:0] SEED   = 16'hACE1,
  parameter int          DIM_W  = (ADDR_W > 1) ? $clog2(ADDR_W) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mode_rand_i,
  input  logic              req_valid_i,
  input  logic [ADDR_W-1:0] self_addr_i,
  input  logic [ADDR_W-1:0] dest_addr_i,
  output logic              port_valid_o,
  output logic [1:0]        port_kind_o,
  output logic [DIM_W-1:0]  port_dim_o
);
  import hhr_pkg::*;

  localparam int CLU_W = ADDR_W - LOC_W;

  logic [LOC_W-1:0]            self_loc, dest_loc, mask;
  logic [CLU_W-1:0]            clu_diff;
  logic [LOC_W-1:0][CNT_W-1:0] counts;
  logic [15:0]                 rnd;
  logic [DIM_W-1:0]            least_idx, rand_idx, upper_idx, link_idx;
  logic [1:0]                  kind_d;
  logic [DIM_W-1:0]            dim_d;
  logic                        inc;

  assign self_loc = self_addr_i[LOC_W-1:0];
  assign dest_loc = dest_addr_i[LOC_W-1:0];
  assign clu_diff = self_addr_i[ADDR_W-1:LOC_W] ^ dest_addr_i[ADDR_W-1:LOC_W];

  always_comb begin
    upper_idx = '0;
    for (int i = CLU_W - 1; i >= 0; i--) begin
      if (clu_diff[i]) upper_idx = DIM_W'(i);
    end
  end

  always_comb begin
    mask   = '0;
    kind_d = KIND_LOCAL;
    if (self_addr_i == dest_addr_i) begin
      kind_d = KIND_LOCAL;
    end else if (clu_diff == '0) begin
      kind_d = KIND_CLUSTER;
      mask   = self_loc ^ dest_loc;
    end else if (self_loc != '0) begin
      kind_d = KIND_CLUSTER;
      mask   = self_loc;
    end else begin
      kind_d = KIND_UPPER;
    end
  end

  hhr_lfsr #(.SEED(SEED)) lfsr_i (
    .clk(clk), .rst(rst), .step_i(req_valid_i), .value_o(rnd)
  );

  hhr_pick_least #(.LOC_W(LOC_W), .CNT_W(CNT_W), .DIM_W(DIM_W)) least_i (
    .mask_i(mask), .count_i(counts), .idx_o(least_idx)
  );

  hhr_pick_random #(.LOC_W(LOC_W), .DIM_W(DIM_W)) random_i (
    .mask_i(mask), .rnd_i(rnd), .idx_o(rand_idx)
  );

  assign link_idx = mode_rand_i ? rand_idx : least_idx;
  assign inc      = req_valid_i && (kind_d == KIND_CLUSTER);

  always_comb begin
    case (kind_d)
      KIND_CLUSTER: dim_d = link_idx;
      KIND_UPPER:   dim_d = upper_idx;
      default:      dim_d = '0;
    endcase
  end

  hhr_link_counters #(.LOC_W(LOC_W), .CNT_W(CNT_W), .DIM_W(DIM_W)) cnt_i (
    .clk(clk), .rst(rst), .inc_i(inc), .idx_i(link_idx), .count_o(counts)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      port_valid_o <= 1'b0;
      port_kind_o  <= KIND_LOCAL;
      port_dim_o   <= '0;
    end else begin
      port_valid_o <= req_valid_i;
      if (req_valid_i) begin
        port_kind_o <= kind_d;
        port_dim_o  <= dim_d;
      end
    end
  end
endmodule

// File: rtl/hhr_router_chk.sv
module hhr_router_chk #(
  parameter int ADDR_W = 6,
  parameter int LOC_W  = 3,
  parameter int DIM_W  = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid_i,
  input logic [ADDR_W-1:0] self_addr_i,
  input logic [ADDR_W-1:0] dest_addr_i,
  input logic              port_valid_o,
  input logic [1:0]        port_kind_o,
  input logic [DIM_W-1:0]  port_dim_o
);
  logic              req_q;
  logic [ADDR_W-1:0] self_q, dest_q;
  logic              same_q, intra_q, gw_q, away_q;
  logic [LOC_W-1:0]  loc_xor_q, self_loc_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      req_q  <= 1'b0;
      self_q <= '0;
      dest_q <= '0;
    end else begin
      req_q  <= req_valid_i;
      self_q <= self_addr_i;
      dest_q <= dest_addr_i;
    end
  end

  assign same_q     = (self_q == dest_q);
  assign intra_q    = !same_q && (self_q[ADDR_W-1:LOC_W] == dest_q[ADDR_W-1:LOC_W]);
  assign gw_q       = (self_q[ADDR_W-1:LOC_W] != dest_q[ADDR_W-1:LOC_W]) && (self_q[LOC_W-1:0] == '0);
  assign away_q     = (self_q[ADDR_W-1:LOC_W] != dest_q[ADDR_W-1:LOC_W]) && (self_q[LOC_W-1:0] != '0);
  assign loc_xor_q  = self_q[LOC_W-1:0] ^ dest_q[LOC_W-1:0];
  assign self_loc_q = self_q[LOC_W-1:0];

  // R1
  valid_align_chk: assert property (@(posedge clk) disable iff (rst)
    port_valid_o == req_q);

  // R2
  local_deliver_chk: assert property (@(posedge clk) disable iff (rst)
    (port_valid_o && same_q) |-> (port_kind_o == 2'd0));

  // R3
  intra_elig_chk: assert property (@(posedge clk) disable iff (rst)
    (port_valid_o && intra_q) |->
      (port_kind_o == 2'd1 && port_dim_o < DIM_W'(LOC_W) &&
       |((loc_xor_q >> port_dim_o) & LOC_W'(1))));

  // R4
  toward_gw_chk: assert property (@(posedge clk) disable iff (rst)
    (port_valid_o && away_q) |->
      (port_kind_o == 2'd1 && |((self_loc_q >> port_dim_o) & LOC_W'(1))));

  // R5
  upper_from_gw_chk: assert property (@(posedge clk) disable iff (rst)
    (port_valid_o && port_kind_o == 2'd2) |-> gw_q);
endmodule

bind hhr_router hhr_router_chk #(.ADDR_W(ADDR_W), .LOC_W(LOC_W), .DIM_W(DIM_W)) chk_i (
  .clk(clk), .rst(rst), .req_valid_i(req_valid_i), .self_addr_i(self_addr_i),
  .dest_addr_i(dest_addr_i), .port_valid_o(port_valid_o),
  .port_kind_o(port_kind_o), .port_dim_o(port_dim_o)
);

// File: tb/hhr_router_tb.sv
`timescale 1ns/1ps
module hhr_router_tb_top;
  localparam int ADDR_W = 6;
  localparam int LOC_W  = 3;
  localparam int CNT_W  = 8;
  localparam int DIM_W  = 3;
  localparam int CMAX   = (1 << CNT_W) - 1;

  logic              clk = 1'b0;
  logic              rst;
  logic              mode_rand_i;
  logic              req_valid_i;
  logic [ADDR_W-1:0] self_addr_i, dest_addr_i;
  logic              port_valid_o;
  logic [1:0]        port_kind_o;
  logic [DIM_W-1:0]  port_dim_o;

  int checks   = 0;
  int failures = 0;
  int cnt [LOC_W];
  bit done = 0;

  always #2.5 clk = ~clk;

  hhr_router #(.ADDR_W(ADDR_W), .LOC_W(LOC_W), .CNT_W(CNT_W)) dut_i (
    .clk(clk), .rst(rst), .mode_rand_i(mode_rand_i), .req_valid_i(req_valid_i),
    .self_addr_i(self_addr_i), .dest_addr_i(dest_addr_i),
    .port_valid_o(port_valid_o), .port_kind_o(port_kind_o), .port_dim_o(port_dim_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_kind(input logic [ADDR_W-1:0] s, input logic [ADDR_W-1:0] d);
    if (s == d) return 0;
    if (s[ADDR_W-1:LOC_W] == d[ADDR_W-1:LOC_W]) return 1;
    if (s[LOC_W-1:0] != 0) return 1;
    return 2;
  endfunction

  function automatic logic [LOC_W-1:0] exp_mask(input logic [ADDR_W-1:0] s, input logic [ADDR_W-1:0] d);
    if (s[ADDR_W-1:LOC_W] == d[ADDR_W-1:LOC_W]) return s[LOC_W-1:0] ^ d[LOC_W-1:0];
    return s[LOC_W-1:0];
  endfunction

  function automatic int exp_upper(input logic [ADDR_W-1:0] s, input logic [ADDR_W-1:0] d);
    for (int i = 0; i < ADDR_W - LOC_W; i++)
      if (s[LOC_W+i] != d[LOC_W+i]) return i;
    return 0;
  endfunction

  function automatic int exp_least(input logic [LOC_W-1:0] m);
    int best = -1;
    for (int i = 0; i < LOC_W; i++)
      if (m[i] && (best < 0 || cnt[i] < cnt[best])) best = i;
    return best;
  endfunction

  task automatic do_reset();
    rst = 1'b1; req_valid_i = 1'b0; mode_rand_i = 1'b0;
    self_addr_i = '0; dest_addr_i = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < LOC_W; i++) cnt[i] = 0;
    @(negedge clk);
  endtask

  task automatic send(input bit md, input logic [ADDR_W-1:0] s, input logic [ADDR_W-1:0] d);
    int k;
    logic [LOC_W-1:0] m;
    int e;
    mode_rand_i = md; self_addr_i = s; dest_addr_i = d; req_valid_i = 1'b1;
    @(negedge clk);
    req_valid_i = 1'b0;
    k = exp_kind(s, d);
    m = exp_mask(s, d);
    check(port_valid_o == 1'b1, "R1", int'(port_valid_o), 1);
    if (k == 0) begin
      check(port_kind_o == 2'd0 && port_dim_o == 0, "R2", int'(port_kind_o), 0);
    end else if (k == 2) begin
      e = exp_upper(s, d);
      check(port_kind_o == 2'd2 && int'(port_dim_o) == e, "R5", int'(port_dim_o), e);
    end else begin
      check(port_kind_o == 2'd1, (s[ADDR_W-1:LOC_W] == d[ADDR_W-1:LOC_W]) ? "R3" : "R4",
            int'(port_kind_o), 1);
      if (md == 1'b0) begin
        e = exp_least(m);
        check(int'(port_dim_o) == e, "R6", int'(port_dim_o), e);
      end else begin
        check(int'(port_dim_o) < LOC_W && m[port_dim_o], "R9", int'(port_dim_o), int'(m));
      end
      if (int'(port_dim_o) < LOC_W && cnt[port_dim_o] < CMAX) cnt[port_dim_o]++;
    end
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [ADDR_W-1:0] s, d;
    void'($urandom(32'd1234));
    do_reset();
    check(port_valid_o == 1'b0, "R1 reset", int'(port_valid_o), 0);
    @(negedge clk);
    check(port_valid_o == 1'b0, "R1 idle", int'(port_valid_o), 0);

    // R2 local delivery
    send(1'b0, 6'o35, 6'o35);
    // R6 tie at zero counts: eligible {0,1,2} -> 0, then 1, then 2
    send(1'b0, 6'o10, 6'o17);
    send(1'b0, 6'o10, 6'o17);
    send(1'b0, 6'o10, 6'o17);
    // R4 away from gateway, R5 from gateway (lowest differing cluster bit)
    send(1'b0, 6'o16, 6'o53);
    send(1'b0, 6'o00, 6'o60);
    send(1'b0, 6'o20, 6'o24);
    // R7 local/upper decisions leave counts: next tie still reflects model
    send(1'b0, 6'o00, 6'o00);
    send(1'b0, 6'o00, 6'o03);
    // R9 random mode eligibility
    for (int i = 0; i < 40; i++) send(1'b1, 6'o30, 6'o37);

    // Random mix
    for (int i = 0; i < 1500; i++) begin
      s = ADDR_W'($urandom);
      d = ADDR_W'($urandom);
      if ($urandom % 2 == 0) d[ADDR_W-1:LOC_W] = s[ADDR_W-1:LOC_W];
      if ($urandom % 16 == 0) d = s;
      send(($urandom % 4) == 0, s, d);
    end

    // R10 reset clears counts: eligible {0,1} picks 0 again
    do_reset();
    send(1'b0, 6'o00, 6'o03);
    check(port_dim_o == 0, "R10", int'(port_dim_o), 0);

    // R8 saturation: 300 on link 0, 100 on link 1, then {0,1} must pick 1
    do_reset();
    for (int i = 0; i < 300; i++) send(1'b0, 6'o00, 6'o01);
    for (int i = 0; i < 100; i++) send(1'b0, 6'o00, 6'o02);
    send(1'b0, 6'o00, 6'o03);
    check(port_dim_o == 1, "R8", int'(port_dim_o), 1);

    @(negedge clk);
    check(port_valid_o == 1'b0, "R1 drop", int'(port_valid_o), 0);
    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule